// File: doc/BRIEF.md
# Serial Word Access Port

This block is a serial slave in SPI mode 0 that gives an external host read and write access to a 32K-word space of 16-bit words. Each transaction opens with CE going low and an 8-bit command byte. Short commands reach registers 0 to 14 by number and go straight to the word-memory port. Other commands go through a 15-bit address pointer. That pointer is register 15 and lives inside the block. The host can load the pointer, read it back, add 1, 2 or 4 to it with single-byte commands, and stream words through it. While CE stays low, the pointer advances after every complete word.

The serial pins are sampled in the block's own system clock domain through a synchronizer. SCK edges are found there, so the word-memory port runs fully synchronously. A read word is fetched as soon as the command or the previous word completes, so it is ready before the first falling SCK edge that must present it. SO comes out as a data bit plus a separate output enable, and the pad ring builds the tristate from these.

Top module: `spi_word_port`

## Requirements
- R1: Bits travel MSB first. SI is taken on rising SCK and SO is updated on falling SCK. A transaction starts with an 8-bit command after CE falls, and SO returns all zeros while the command byte is shifted.
- R2: `spi_so_en` is high exactly while `spi_cs_n` is low, so SO is released (high impedance) whenever CE is high.
- R3: A command with bit 7 = 0, bit 6 = 0, bits 1:0 = 00 and register number N = bits 5:2 in 0..14 reads memory word N. The word is returned MSB first during the next 16 SCK clocks.
- R4: The same pattern with bit 7 = 1 writes the following 16-bit word to memory address N once all 16 bits have arrived. Any further clocks in that transaction are ignored.
- R5: Command 0xBC loads the pointer with bits 14:0 of the following word, and bit 15 is ignored. Command 0x3C returns the pointer as a 16-bit word with bit 15 = 0.
- R6: Command 0x40 reads the word at the pointer. Each completed word adds 1 to the pointer, and the next word is streamed while CE stays low.
- R7: Command 0xC0 writes each completed incoming word to the pointer address and then adds 1 to the pointer.
- R8: Pointer arithmetic is modulo 2^15, so 0x7FFF plus 1 gives 0x0000.
- R9: Commands 0xD0, 0xD8 and 0xE0 add 1, 2 and 4 to the pointer at the end of the command byte, without any memory access.
- R10: Any other command byte (for example 0xFF, 0x41, 0x01) is ignored until CE rises. There is no memory access, the pointer does not change and SO stays 0.
- R11: A word that is only partly shifted when CE rises is discarded. Nothing is written and the pointer does not change.
- R12: Reset clears the pointer to 0 and no memory access takes place.
- R13: Each memory access is a one-cycle `mem_en` strobe. For a read, `mem_rdata` is taken one cycle after the strobe. SCK high and low times must each be at least 6 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Chip enable, active low |
| spi_si | input | 1 | Serial data from host |
| spi_so | output | 1 | Serial data to host |
| spi_so_en | output | 1 | Output enable for SO pad |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | WORD_W | Write data |
| mem_rdata | input | WORD_W | Read data, valid one cycle after a read strobe |

## Verification
The hardest situation to reach is a streamed read that crosses the top of the address space. There, the prefetch for the next word must wrap to address 0 while the current word is still being shifted out. The bench loads the pointer with 0x7FFF through the load command, then holds CE low across two words and checks the second word and the pointer read back afterwards. The other hard case is a CE release in the middle of a word. The bench stops clocking after 9 of 16 data bits, closes the transaction, and reads the pointer back to show that nothing moved.

// File: rtl/spi_word_port_pkg.sv
package spi_word_port_pkg;

  localparam int CMD_W = 8;
  localparam int REG_W = 4;

  localparam logic [CMD_W-1:0] OP_PTR_RD  = 8'h40;
  localparam logic [CMD_W-1:0] OP_PTR_WR  = 8'hC0;
  localparam logic [CMD_W-1:0] OP_ADD_ONE = 8'hD0;
  localparam logic [CMD_W-1:0] OP_ADD_TWO = 8'hD8;
  localparam logic [CMD_W-1:0] OP_ADD_FOUR = 8'hE0;

  typedef enum logic [1:0] {PH_CMD, PH_DATA, PH_SKIP} phase_t;

  typedef enum logic [2:0] {
    K_REG_RD, K_REG_WR, K_PTR_GET, K_PTR_SET, K_IND_RD, K_IND_WR
  } kind_t;

  typedef struct packed {
    logic             valid;
    logic             is_add;
    logic [2:0]       add_amt;
    kind_t            kind;
    logic [REG_W-1:0] reg_idx;
  } cmd_dec_t;

  function automatic cmd_dec_t decode_cmd(input logic [CMD_W-1:0] b);
    cmd_dec_t d;
    d = '{valid: 1'b0, is_add: 1'b0, add_amt: 3'd0, kind: K_REG_RD, reg_idx: '0};
    if (!b[6] && (b[1:0] == 2'b00)) begin
      d.valid   = 1'b1;
      d.reg_idx = b[5:2];
      if (b[5:2] == 4'hF) d.kind = b[7] ? K_PTR_SET : K_PTR_GET;
      else                d.kind = b[7] ? K_REG_WR  : K_REG_RD;
    end else begin
      case (b)
        OP_PTR_RD:   begin d.valid = 1'b1; d.kind = K_IND_RD; end
        OP_PTR_WR:   begin d.valid = 1'b1; d.kind = K_IND_WR; end
        OP_ADD_ONE:  begin d.is_add = 1'b1; d.add_amt = 3'd1; end
        OP_ADD_TWO:  begin d.is_add = 1'b1; d.add_amt = 3'd2; end
        OP_ADD_FOUR: begin d.is_add = 1'b1; d.add_amt = 3'd4; end
        default:     d.valid = 1'b0;
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/spi_wp_sync.sv
module spi_wp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic si_s
);

  localparam int LANES = 3;
  localparam logic [LANES-1:0] IDLE_VAL = 3'b010;

  logic [STAGES-1:0][LANES-1:0] chain_q, chain_d;
  logic sck_prev_q, sck_prev_d;
  logic sck_s, cs_n_s;

  always_comb begin
    chain_d    = {chain_q[STAGES-2:0], {sck, cs_n, si}};
    sck_prev_d = sck_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q    <= {STAGES{IDLE_VAL}};
      sck_prev_q <= 1'b0;
    end else begin
      chain_q    <= chain_d;
      sck_prev_q <= sck_prev_d;
    end
  end

  assign sck_s    = chain_q[STAGES-1][2];
  assign cs_n_s   = chain_q[STAGES-1][1];
  assign si_s     = chain_q[STAGES-1][0];
  assign cs_act   = ~cs_n_s;
  assign sck_rise = cs_act &  sck_s & ~sck_prev_q;
  assign sck_fall = cs_act & ~sck_s &  sck_prev_q;

endmodule

// File: rtl/spi_wp_shift.sv
module spi_wp_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              si_s,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_word,
  output logic [WORD_W-1:0] rx_next,
  output logic              so_bit
);

  logic [WORD_W-1:0] rx_q, rx_d;
  logic [WORD_W-1:0] tx_q, tx_d;

  assign rx_next = {rx_q[WORD_W-2:0], si_s};

  always_comb begin
    rx_d = rx_q;
    tx_d = tx_q;
    if (sck_rise) rx_d = rx_next;
    if (!cs_act) begin
      tx_d = '0;
    end else if (sck_fall) begin
      tx_d = load_en ? load_word : {tx_q[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
      tx_q <= '0;
    end else begin
      rx_q <= rx_d;
      tx_q <= tx_d;
    end
  end

  assign so_bit = tx_q[WORD_W-1];

endmodule

// File: rtl/spi_wp_ctrl.sv
module spi_wp_ctrl
  import spi_word_port_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic [WORD_W-1:0] rx_next,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              load_en,
  output logic [WORD_W-1:0] load_word,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] ptr,
  output logic              ptr_load
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);

  phase_t            phase_q, phase_d;
  kind_t             kind_q, kind_d;
  logic [REG_W-1:0]  reg_q, reg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              arm_q, arm_d;
  logic [WORD_W-1:0] hold_q, hold_d;
  logic              rdcap_q, rdcap_d;
  logic              men_q, men_d;
  logic              mwe_q, mwe_d;
  logic [ADDR_W-1:0] maddr_q, maddr_d;
  logic [WORD_W-1:0] mwdata_q, mwdata_d;
  cmd_dec_t          dec;
  logic [ADDR_W-1:0] ptr_inc;
  logic [ADDR_W-1:0] reg_addr;

  assign dec      = decode_cmd(rx_next[CMD_W-1:0]);
  assign ptr_inc  = ptr_q + ADDR_W'(1);
  assign reg_addr = ADDR_W'(reg_q);

  always_comb begin
    phase_d  = phase_q;
    kind_d   = kind_q;
    reg_d    = reg_q;
    cnt_d    = cnt_q;
    ptr_d    = ptr_q;
    arm_d    = arm_q;
    hold_d   = hold_q;
    men_d    = 1'b0;
    mwe_d    = 1'b0;
    maddr_d  = maddr_q;
    mwdata_d = mwdata_q;
    rdcap_d  = men_q & ~mwe_q;
    ptr_load = 1'b0;

    if (rdcap_q) hold_d = mem_rdata;
    if (sck_fall && arm_q) arm_d = 1'b0;

    if (!cs_act) begin
      phase_d = PH_CMD;
      cnt_d   = '0;
      arm_d   = 1'b0;
    end else if (sck_rise) begin
      cnt_d = cnt_q + CNT_W'(1);
      case (phase_q)
        PH_CMD: begin
          if (cnt_q == CMD_LAST) begin
            cnt_d = '0;
            if (dec.is_add) begin
              ptr_d   = ptr_q + ADDR_W'(dec.add_amt);
              phase_d = PH_SKIP;
            end else if (!dec.valid) begin
              phase_d = PH_SKIP;
            end else begin
              phase_d = PH_DATA;
              kind_d  = dec.kind;
              reg_d   = dec.reg_idx;
              case (dec.kind)
                K_REG_RD: begin
                  men_d   = 1'b1;
                  maddr_d = ADDR_W'(dec.reg_idx);
                  arm_d   = 1'b1;
                end
                K_PTR_GET: begin
                  hold_d = WORD_W'(ptr_q);
                  arm_d  = 1'b1;
                end
                K_IND_RD: begin
                  men_d   = 1'b1;
                  maddr_d = ptr_q;
                  arm_d   = 1'b1;
                end
                default: ;
              endcase
            end
          end
        end
        PH_DATA: begin
          if (cnt_q == WORD_LAST) begin
            cnt_d = '0;
            case (kind_q)
              K_REG_WR: begin
                men_d    = 1'b1;
                mwe_d    = 1'b1;
                maddr_d  = reg_addr;
                mwdata_d = rx_next;
                phase_d  = PH_SKIP;
              end
              K_PTR_SET: begin
                ptr_d    = rx_next[ADDR_W-1:0];
                ptr_load = 1'b1;
                phase_d  = PH_SKIP;
              end
              K_IND_RD: begin
                ptr_d   = ptr_inc;
                men_d   = 1'b1;
                maddr_d = ptr_inc;
                arm_d   = 1'b1;
              end
              K_IND_WR: begin
                ptr_d    = ptr_inc;
                men_d    = 1'b1;
                mwe_d    = 1'b1;
                maddr_d  = ptr_q;
                mwdata_d = rx_next;
              end
              default: phase_d = PH_SKIP;
            endcase
          end
        end
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_CMD;
      kind_q   <= K_REG_RD;
      reg_q    <= '0;
      cnt_q    <= '0;
      ptr_q    <= '0;
      arm_q    <= 1'b0;
      hold_q   <= '0;
      rdcap_q  <= 1'b0;
      men_q    <= 1'b0;
      mwe_q    <= 1'b0;
      maddr_q  <= '0;
      mwdata_q <= '0;
    end else begin
      phase_q  <= phase_d;
      kind_q   <= kind_d;
      reg_q    <= reg_d;
      cnt_q    <= cnt_d;
      ptr_q    <= ptr_d;
      arm_q    <= arm_d;
      hold_q   <= hold_d;
      rdcap_q  <= rdcap_d;
      men_q    <= men_d;
      mwe_q    <= mwe_d;
      maddr_q  <= maddr_d;
      mwdata_q <= mwdata_d;
    end
  end

  assign load_en   = arm_q;
  assign load_word = hold_q;
  assign mem_en    = men_q;
  assign mem_we    = mwe_q;
  assign mem_addr  = maddr_q;
  assign mem_wdata = mwdata_q;
  assign ptr       = ptr_q;

endmodule

// File: rtl/spi_word_port.sv
module spi_word_port #(
  parameter int WORD_W      = 16,
  parameter int ADDR_W      = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  output logic              spi_so,
  output logic              spi_so_en,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);

  logic              sck_rise, sck_fall, cs_act, si_s;
  logic              load_en;
  logic [WORD_W-1:0] load_word, rx_next;
  logic [ADDR_W-1:0] ptr;
  logic              ptr_load;

  spi_wp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .si(spi_si),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act), .si_s(si_s)
  );

  spi_wp_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .si_s(si_s), .load_en(load_en),
    .load_word(load_word), .rx_next(rx_next), .so_bit(spi_so)
  );

  spi_wp_ctrl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .rx_next(rx_next), .mem_rdata(mem_rdata),
    .load_en(load_en), .load_word(load_word), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .ptr(ptr), .ptr_load(ptr_load)
  );

  assign spi_so_en = ~spi_cs_n;

endmodule

// File: rtl/spi_wp_chk.sv
module spi_wp_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] ptr,
  input logic              ptr_load
);

  logic [ADDR_W-1:0] prev_q;
  logic              ld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      ld_q   <= 1'b0;
    end else begin
      prev_q <= ptr;
      ld_q   <= ptr_load;
    end
  end

  // R12: reset holds the pointer at zero with no access
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r12_reset_idle: assert (ptr == '0 && !mem_en);
    end
  end

  // R13: memory strobe lasts one cycle
  a_r13_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |=> !mem_en);

  // R10: no memory access unless a transaction was open
  a_r10_access_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> $past(cs_act));

  // R11: pointer cannot move while CE is released
  a_r11_ptr_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && $past(!cs_act)) |-> $stable(ptr));

  // R9 / R8: any change that is not a load is a step of 1, 2 or 4 modulo 2^ADDR_W
  a_r9_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != prev_q && !ld_q) |->
      (ptr == prev_q + ADDR_W'(1) || ptr == prev_q + ADDR_W'(2) ||
       ptr == prev_q + ADDR_W'(4)));

  // R4: writes never follow writes on back-to-back cycles
  a_r4_write_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |=> !(mem_en && mem_we));

endmodule

bind spi_word_port spi_wp_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .mem_en(mem_en),
  .mem_we(mem_we), .ptr(ptr), .ptr_load(ptr_load)
);

// File: tb/tb_spi_word_port.sv
module tb_spi_word_port;

  localparam int WORD_W = 16;
  localparam int ADDR_W = 15;
  localparam int HALF   = 8;

  logic clk, rst_n;
  logic spi_sck, spi_cs_n, spi_si;
  logic spi_so, spi_so_en;
  logic mem_en, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [WORD_W-1:0] mem_wdata, mem_rdata;

  int checks = 0;
  int errs   = 0;
  int acc_cnt = 0;
  int wr_cnt  = 0;
  logic [ADDR_W-1:0] wr_addr_log [8];
  logic [WORD_W-1:0] wr_data_log [8];

  spi_word_port #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_si(spi_si), .spi_so(spi_so), .spi_so_en(spi_so_en),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [WORD_W-1:0] pat(input logic [ADDR_W-1:0] a);
    return {a[7:0], ~a[7:0]};
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) begin
        wr_addr_log[wr_cnt % 8] <= mem_addr;
        wr_data_log[wr_cnt % 8] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      mem_rdata <= pat(mem_addr);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input int n, input logic [15:0] dout, output logic [15:0] din);
    din = '0;
    for (int i = n - 1; i >= 0; i--) begin
      spi_si = dout[i];
      wait_clk(HALF);
      din = {din[14:0], spi_so};
      spi_sck = 1'b1;
      wait_clk(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic open_txn();
    spi_cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic close_txn();
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic read_ptr(output logic [15:0] v);
    logic [15:0] d;
    open_txn();
    xfer(8, 16'h3C, d);
    xfer(16, 16'h0, v);
    close_txn();
  endtask

  task automatic load_ptr(input logic [15:0] v);
    logic [15:0] d;
    open_txn();
    xfer(8, 16'hBC, d);
    xfer(16, v, d);
    close_txn();
  endtask

  task automatic one_byte(input logic [7:0] c);
    logic [15:0] d;
    open_txn();
    xfer(8, {8'h0, c}, d);
    close_txn();
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R2 so_en with CE high", spi_so_en, 1'b0);
    chk("R12 no access after reset", acc_cnt, 0);
    read_ptr(v);
    chk("R12 pointer after reset", v, 16'h0000);
  endtask

  task automatic t_fast_read();
    logic [15:0] d, w;
    int a0;
    a0 = acc_cnt;
    open_txn();
    chk("R2 so_en with CE low", spi_so_en, 1'b1);
    xfer(8, 16'h14, d);
    chk("R1 dummy byte during command", d, 16'h0000);
    xfer(16, 16'h0, w);
    close_txn();
    chk("R3 read register 5", w, pat(15'd5));
    chk("R13 one strobe per read", acc_cnt - a0, 1);
    open_txn();
    xfer(8, 16'h38, d);
    xfer(16, 16'h0, w);
    close_txn();
    chk("R3 read register 14", w, pat(15'd14));
  endtask

  task automatic t_fast_write();
    logic [15:0] d;
    int w0;
    w0 = wr_cnt;
    open_txn();
    xfer(8, 16'hA4, d);
    xfer(16, 16'hBEEF, d);
    xfer(16, 16'h1234, d);
    close_txn();
    chk("R4 single write", wr_cnt - w0, 1);
    chk("R4 write address", wr_addr_log[w0 % 8], 15'd9);
    chk("R4 write data", wr_data_log[w0 % 8], 16'hBEEF);
  endtask

  task automatic t_ptr_load();
    logic [15:0] v;
    load_ptr(16'hFFFF);
    read_ptr(v);
    chk("R5 load ignores bit 15", v, 16'h7FFF);
    load_ptr(16'h1234);
    read_ptr(v);
    chk("R5 load and read back", v, 16'h1234);
  endtask

  task automatic t_ind_read();
    logic [15:0] d, w, v;
    load_ptr(16'h0010);
    open_txn();
    xfer(8, 16'h40, d);
    for (int k = 0; k < 3; k++) begin
      xfer(16, 16'h0, w);
      chk("R6 streamed read word", w, pat(15'(16 + k)));
    end
    close_txn();
    read_ptr(v);
    chk("R6 pointer after three words", v, 16'h0013);
  endtask

  task automatic t_ind_write();
    logic [15:0] d, v;
    int w0;
    load_ptr(16'h0020);
    w0 = wr_cnt;
    open_txn();
    xfer(8, 16'hC0, d);
    for (int k = 0; k < 3; k++) xfer(16, 16'hA000 + 16'(k), d);
    close_txn();
    chk("R7 write count", wr_cnt - w0, 3);
    for (int k = 0; k < 3; k++) begin
      chk("R7 write address", wr_addr_log[(w0 + k) % 8], 15'(32 + k));
      chk("R7 write data", wr_data_log[(w0 + k) % 8], 16'hA000 + 16'(k));
    end
    read_ptr(v);
    chk("R7 pointer after writes", v, 16'h0023);
  endtask

  task automatic t_wrap();
    logic [15:0] d, w, v;
    load_ptr(16'h7FFF);
    open_txn();
    xfer(8, 16'h40, d);
    xfer(16, 16'h0, w);
    chk("R8 word at top address", w, pat(15'h7FFF));
    xfer(16, 16'h0, w);
    chk("R8 word after wrap", w, pat(15'h0000));
    close_txn();
    read_ptr(v);
    chk("R8 pointer after wrap", v, 16'h0001);
  endtask

  task automatic t_add();
    logic [15:0] v;
    int a0;
    load_ptr(16'h0100);
    a0 = acc_cnt;
    one_byte(8'hD0);
    read_ptr(v);
    chk("R9 add one", v, 16'h0101);
    one_byte(8'hD8);
    read_ptr(v);
    chk("R9 add two", v, 16'h0103);
    one_byte(8'hE0);
    read_ptr(v);
    chk("R9 add four", v, 16'h0107);
    chk("R9 no memory access", acc_cnt - a0, 0);
    load_ptr(16'h7FFE);
    one_byte(8'hE0);
    read_ptr(v);
    chk("R8 add four wraps", v, 16'h0002);
  endtask

  task automatic t_unknown();
    logic [15:0] d, w, v;
    logic [7:0] ops [3];
    int a0;
    ops = '{8'hFF, 8'h41, 8'h01};
    load_ptr(16'h0200);
    a0 = acc_cnt;
    for (int k = 0; k < 3; k++) begin
      open_txn();
      xfer(8, {8'h0, ops[k]}, d);
      xfer(16, 16'hFFFF, w);
      close_txn();
      chk("R10 SO stays zero", w, 16'h0000);
    end
    chk("R10 no memory access", acc_cnt - a0, 0);
    read_ptr(v);
    chk("R10 pointer unchanged", v, 16'h0200);
  endtask

  task automatic t_partial();
    logic [15:0] d, v;
    int w0;
    load_ptr(16'h0030);
    w0 = wr_cnt;
    open_txn();
    xfer(8, 16'hC0, d);
    xfer(9, 16'h01FF, d);
    close_txn();
    open_txn();
    xfer(8, 16'hA4, d);
    xfer(12, 16'h0ABC, d);
    close_txn();
    chk("R11 no write from partial word", wr_cnt - w0, 0);
    read_ptr(v);
    chk("R11 pointer unchanged", v, 16'h0030);
  endtask

  logic done = 1'b0;

  initial begin
    rst_n = 1'b0;
    spi_sck = 1'b0;
    spi_cs_n = 1'b1;
    spi_si = 1'b0;
    mem_rdata = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_fast_read();
    t_fast_write();
    t_ptr_load();
    t_ind_read();
    t_ind_write();
    t_wrap();
    t_add();
    t_unknown();
    t_partial();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule